// File: doc/BRIEF.md
# Hierarchical Radix-4 Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in in a single combinational pass. Every carry comes from a lookahead tree instead of a ripple chain. The tree is built from one cell that takes four propagate/generate pairs and a carry-in. That cell returns the three inner carries and a combined pair for the group.

The same cell is used at every level of the tree:

- Over bit columns it produces the carries inside each nibble.
- Over nibble pairs it produces the carries between nibbles of a 16-bit section.
- Over section pairs it produces the carries between 16-bit sections.

A width parameter of 4, 16 or 64 selects one, two or three levels.

Each bit column forms its propagate as the OR of the two operand bits and its generate as their AND. Because the OR-based propagate is not the half-sum, the sum bits use a separate XOR of the operand bits with the incoming carry. The root pair of the tree is exported as `p_top` and `g_top`. The carry-out is derived from that root pair and the carry-in.

Top module: `cla_adder`

## Requirements
- R1: For any operands and carry-in, {cout, sum} equals a + b + cin taken as an unsigned value one bit wider than the operands.
- R2: p_top is 1 exactly when every bit position has at least one of a or b set.
- R3: g_top is 1 exactly when a + b with a carry-in of 0 overflows the operand width.
- R4: cout equals g_top OR (p_top AND cin). A set g_top forces cout to 1, and with both p_top and g_top clear cout is 0.
- R5: When every column propagates but none generates (for example a = 0xAAAA..., b = 0x5555...) and cin is 1, the carry crosses all levels: sum is 0 and cout is 1.
- R6: All-ones plus one with cin 0 gives sum 0, cout 1 and g_top 1.
- R7: Zero plus zero with cin 0 gives sum 0, cout 0, p_top 0 and g_top 0.
- R8: The widths 4 and 16 give results that meet R1 at their own width.
- R9: A carry generated in one nibble or 16-bit section reaches every higher position whose columns propagate. For example, 0x0000FFFFFFFFFFFF + 1 gives 0x0001000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |
| p_top | output | 1 | Propagate of the whole word (root of the tree) |
| g_top | output | 1 | Generate of the whole word (root of the tree) |

## Verification
Zero plus zero and all-ones plus one test the two extremes of the root generate. An alternating pattern with carry-in 1 is a pure propagate chain, so it shows whether the carry-in reaches the top through every level without any generate term helping. Operands with a single generating column just below a nibble or section boundary show whether group carries are steered into the right lower-level cell. Random operands on all three widths test the general sum and the root propagate/generate pair against the plain arithmetic sum.

// File: rtl/cla_pkg.sv
// cla_pkg: shared constants and elaboration-time helpers for the lookahead tree.
// Assumes the word width is a power of the radix (4, 16, 64, ...).
package cla_pkg;

    localparam int RADIX = 4;

    // Number of lookahead levels needed to reduce w columns to one root node.
    function automatic int cla_levels(input int w);
        int n;
        int l;
        n = w;
        l = 0;
        for (int k = 0; k < 8; k++) begin
            if (n > 1) begin
                n = n / RADIX;
                l = l + 1;
            end
        end
        return l;
    endfunction

    // Index of the first node of level lvl in the flat node vector.
    function automatic int cla_node_base(input int w, input int lvl);
        int n;
        int base;
        n = w;
        base = 0;
        for (int k = 0; k < 8; k++) begin
            if (k < lvl) begin
                base = base + n;
                n = n / RADIX;
            end
        end
        return base;
    endfunction

endpackage

// File: rtl/cla_pg_bit.sv
// cla_pg_bit: per-column terms for one bit position.
// Produces OR-propagate, AND-generate and the XOR half-sum used by the sum bit.
module cla_pg_bit (
    input  logic a_bit,
    input  logic b_bit,
    output logic prop,
    output logic gen,
    output logic half
);

    // Column terms, all from the two operand bits only.
    always_comb begin
        prop = a_bit | b_bit;
        gen  = a_bit & b_bit;
        half = a_bit ^ b_bit;
    end

endmodule

// File: rtl/cla_cell.sv
// cla_cell: one radix-N carry-lookahead cell, reused at every level of the tree.
// Every carry is a flat sum of products of p, g and cin, with no internal ripple.
// Assumes N is small (4 gives a widest term of five inputs).
module cla_cell #(
    parameter int N = cla_pkg::RADIX
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         cin,
    output logic [N-2:0] carry,   // carry[k] enters position k+1
    output logic         grp_p,
    output logic         grp_g
);

    // Carry out of position k, expanded: g_k + p_k g_(k-1) + ... + p_k..p_0 ci.
    function automatic logic expand(input logic [N-1:0] pp,
                                    input logic [N-1:0] gg,
                                    input logic         ci,
                                    input int           k);
        logic s;
        logic t;
        t = ci;
        for (int m = 0; m < N; m++) begin
            if (m <= k) t = t & pp[m];
        end
        s = t;
        for (int j = 0; j < N; j++) begin
            if (j <= k) begin
                t = gg[j];
                for (int m = 0; m < N; m++) begin
                    if (m > j && m <= k) t = t & pp[m];
                end
                s = s | t;
            end
        end
        return s;
    endfunction

    // Inner carries and the combined group pair.
    always_comb begin
        for (int k = 0; k < N - 1; k++) begin
            carry[k] = expand(p, g, cin, k);
        end
        grp_p = &p;
        grp_g = expand(p, g, 1'b0, N - 1);
    end

endmodule

// File: rtl/cla_adder.sv
// cla_adder: WIDTH-bit adder built from a recursive tree of identical lookahead cells.
// Node layout: level 0 holds one node per bit, and each higher level holds one
// node per group of four below it. The root is the last node.
// Carries flow from the root down. Group pairs flow from the bits up.
// Assumes WIDTH is 4, 16 or 64. Purely combinational.
module cla_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             p_top,
    output logic             g_top
);
    import cla_pkg::*;

    localparam int LEVELS = cla_levels(WIDTH);
    localparam int NODES  = cla_node_base(WIDTH, LEVELS) + 1;
    localparam int ROOT   = NODES - 1;

    logic [NODES-1:0] np;
    logic [NODES-1:0] ng;
    logic [NODES-1:0] nc;
    logic [WIDTH-1:0] half;

    // Bit columns: level-0 nodes and the sum bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
        cla_pg_bit u_col (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .prop  (np[i]),
            .gen   (ng[i]),
            .half  (half[i])
        );
        assign sum[i] = half[i] ^ nc[i];
    end

    // Lookahead levels: each cell folds four nodes into one node of the next level.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int BASE = cla_node_base(WIDTH, l);
        localparam int UP   = cla_node_base(WIDTH, l + 1);
        localparam int CNT  = WIDTH >> (2 * (l + 1));
        for (genvar c = 0; c < CNT; c++) begin : g_cell
            cla_cell #(.N(RADIX)) u_cell (
                .p     (np[BASE + RADIX*c +: RADIX]),
                .g     (ng[BASE + RADIX*c +: RADIX]),
                .cin   (nc[UP + c]),
                .carry (nc[BASE + RADIX*c + 1 +: RADIX-1]),
                .grp_p (np[UP + c]),
                .grp_g (ng[UP + c])
            );
            assign nc[BASE + RADIX*c] = nc[UP + c];
        end
    end

    // Root: the external carry enters at the top node, and the word pair is exported.
    assign nc[ROOT] = cin;
    assign p_top    = np[ROOT];
    assign g_top    = ng[ROOT];
    assign cout     = ng[ROOT] | (np[ROOT] & cin);

endmodule

// File: rtl/cla_adder_chk.sv
// cla_adder_chk: property checker for cla_adder, attached by bind.
// Compares the port values against a flat arithmetic model once they settle.
module cla_adder_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             p_top,
    input logic             g_top
);

    logic [WIDTH:0] ref_full;
    logic [WIDTH:0] ref_nocin;

    // Flat reference sums and checks against the tree outputs.
    always_comb begin
        ref_full  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        ref_nocin = {1'b0, a} + {1'b0, b};
        a_r1_sum_matches: assert ({cout, sum} == ref_full)
            else $error("R1 sum mismatch");
        a_r2_word_prop: assert (p_top == (&(a | b)))
            else $error("R2 word propagate mismatch");
        a_r3_word_gen: assert (g_top == ref_nocin[WIDTH])
            else $error("R3 word generate mismatch");
        a_r4_gen_forces_cout: assert (!g_top || cout)
            else $error("R4 generate without carry-out");
        a_r4_prop_cin_cout: assert (!(p_top && cin) || cout)
            else $error("R4 propagate chain lost carry");
        a_r4_kill_no_cout: assert (p_top || g_top || !cout)
            else $error("R4 carry-out without propagate or generate");
    end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .p_top (p_top),
    .g_top (g_top)
);

// File: tb/cla_adder_test.sv
// cla_adder_test: directed bench for cla_adder at widths 64, 16 and 4.
module cla_adder_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;

    logic [63:0] a, b, s;
    logic        ci, co, pt, gt;
    logic [15:0] a16, b16, s16;
    logic        c16, co16, pt16, gt16;
    logic [3:0]  a4, b4, s4;
    logic        c4, co4, pt4, gt4;

    cla_adder #(.WIDTH(64)) uut (
        .a(a), .b(b), .cin(ci), .sum(s), .cout(co), .p_top(pt), .g_top(gt));
    cla_adder #(.WIDTH(16)) uut16 (
        .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16), .p_top(pt16), .g_top(gt16));
    cla_adder #(.WIDTH(4)) uut4 (
        .a(a4), .b(b4), .cin(c4), .sum(s4), .cout(co4), .p_top(pt4), .g_top(gt4));

    // Record one comparison.
    task automatic expect_eq(input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive the 64-bit adder, then check sum (R1), p_top (R2), g_top (R3) and cout (R4).
    task automatic try64(input string tag, input logic [63:0] x, input logic [63:0] y,
                         input logic c);
        logic [64:0] full;
        logic [64:0] nocin;
        logic        pe;
        @(posedge clk);
        a = x; b = y; ci = c;
        @(negedge clk);
        full  = {1'b0, x} + {1'b0, y} + {64'd0, c};
        nocin = {1'b0, x} + {1'b0, y};
        pe    = &(x | y);
        expect_eq({tag, " R1 sum"}, {co, s}, full);
        expect_eq({tag, " R2 p_top"}, {64'd0, pt}, {64'd0, pe});
        expect_eq({tag, " R3 g_top"}, {64'd0, gt}, {64'd0, nocin[64]});
        expect_eq({tag, " R4 cout"}, {64'd0, co}, {64'd0, nocin[64] | (pe & c)});
    endtask

    // R7: zero plus zero, also the starting state.
    task automatic t_zero();
        try64("R7 zero", 64'd0, 64'd0, 1'b0);
        expect_eq("R7 all outputs clear", {co, s}, 65'd0);
        expect_eq("R7 p_top g_top", {63'd0, pt, gt}, 65'd0);
    endtask

    // R6: all-ones plus one.
    task automatic t_ones_plus_one();
        try64("R6 ones+1", '1, 64'd1, 1'b0);
        expect_eq("R6 result", {gt, co, s}, {2'b11, 64'd0});
    endtask

    // R5: pure propagate chains carried by cin alone.
    task automatic t_prop_chain();
        try64("R5 alt", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
        expect_eq("R5 alt result", {co, s}, {1'b1, 64'd0});
        try64("R5 ones", '1, 64'd0, 1'b1);
        expect_eq("R5 ones result", {co, s}, {1'b1, 64'd0});
        try64("R5 no cin", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
        expect_eq("R5 no cin result", {co, s}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    // R9: generates at nibble and section edges travelling upward.
    task automatic t_boundaries();
        try64("R9 nibble", 64'h0000_0000_0000_000F, 64'd1, 1'b0);
        expect_eq("R9 nibble result", {co, s}, {1'b0, 64'h10});
        try64("R9 section", 64'h0000_0000_0000_FFFF, 64'd1, 1'b0);
        expect_eq("R9 section result", {co, s}, {1'b0, 64'h1_0000});
        try64("R9 three sections", 64'h0000_FFFF_FFFF_FFFF, 64'd1, 1'b0);
        expect_eq("R9 three result", {co, s}, {1'b0, 64'h0001_0000_0000_0000});
        try64("R9 gen bit3", 64'hFFFF_FFFF_FFFF_FFF8, 64'h8, 1'b0);
        expect_eq("R9 gen bit3 result", {co, s}, {1'b1, 64'd0});
        try64("R9 gen bit47", 64'h0000_8000_0000_0000, 64'h7FFF_8000_0000_0000, 1'b0);
    endtask

    // R1: random operands on the 64-bit instance.
    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            try64("R1 random", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end
    endtask

    // R8: the narrow instances.
    task automatic t_widths();
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
            a4  = 4'($urandom);  b4  = 4'($urandom);  c4  = 1'($urandom);
            @(negedge clk);
            expect_eq("R8 width16 sum", {48'd0, co16, s16},
                      {48'd0, {1'b0, a16} + {1'b0, b16} + {16'd0, c16}});
            expect_eq("R8 width4 sum", {60'd0, co4, s4},
                      {60'd0, {1'b0, a4} + {1'b0, b4} + {4'd0, c4}});
            expect_eq("R8 width16 p_top", {64'd0, pt16}, {64'd0, &(a16 | b16)});
            expect_eq("R8 width4 g_top", {64'd0, gt4}, {64'd0, ({1'b0, a4} + {1'b0, b4}) >> 4});
        end
        @(posedge clk);
        a16 = '1; b16 = 16'd1; c16 = 1'b0;
        @(negedge clk);
        expect_eq("R8 width16 ones+1", {48'd0, gt16, co16, s16}, {48'd0, 2'b11, 16'd0});
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        fork
            begin
                t_zero();
                t_ones_plus_one();
                t_prop_chain();
                t_boundaries();
                t_random();
                t_widths();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule